// File: doc/BRIEF.md
# Three-Mode Interrupt Acceptance Unit

This block decides, for an 8-bit processor core, whether an interrupt is taken at the end of each instruction, and it runs the entry sequence that follows. It keeps two interrupt enable flip-flops (a live one and a saved copy) and a 2-bit mode register. It watches an active-low, level-sensitive maskable request and an active-low non-maskable request whose falling edge is captured. The core reports each instruction boundary and, in the same cycle, flags the interrupt-related instruction that just completed: disable, enable, mode select, or return-from-non-maskable.

When an interrupt is taken, the unit stays busy for the entry length of that kind. A maskable entry opens with an acknowledge cycle, and the byte the device drives on the data bus is captured in that cycle. Mode 0 hands the captured byte to the core as an opcode. Mode 1 requests a push of PC and jumps to 0x0038. Mode 2 requests a push and a read from a table word whose address is formed from the page register and the device byte. A non-maskable entry requests a push and jumps to 0x0066.

Top module: `intr_accept_unit`

## Requirements
- R1: After reset both enable flip-flops are 0, the mode is 0, no entry is running, no non-maskable request is pending, and all entry strobes are low.
- R2: A maskable entry starts only at a boundary where irq_ni is low, no entry is running, and the live enable is set once the completing instruction's effect is applied. A boundary that completes disable (di_i) therefore takes nothing.
- R3: The boundary that completes enable (ei_i) never starts a maskable entry. The next boundary with irq_ni low does start one.
- R4: A falling edge on nmi_ni, even one only a single cycle low, stays pending until a non-maskable entry starts. Holding nmi_ni low after it has been serviced starts no second entry.
- R5: A pending non-maskable request wins over a simultaneous maskable request. It is taken whatever the enable flip-flops hold, and it has no acknowledge cycle.
- R6: A non-maskable entry copies the live enable into the saved one, clears the live one, requests a push in its second cycle and jumps to 0x0066 in its last cycle. A boundary with retn_i copies the saved enable back into the live one.
- R7: A maskable entry clears both enable flip-flops.
- R8: Mode 1 (im_sel_i = 1) pulses ack_o in cycle 1, push_pc_o in cycle 2, and jump_o with target_o = 0x0038 in the last cycle.
- R9: Mode 2 (im_sel_i = 2) pulses ack_o in cycle 1 and push_pc_o and tbl_rd_o in cycle 2. In that cycle tbl_addr_o has page_i in bits 15:8 and bus_i in bits 7:1, with bit 0 forced to 0; both inputs are sampled in cycle 1.
- R10: Mode 0 (im_sel_i = 0) pulses ack_o in cycle 1, then op_vld_o with op_o equal to the bus_i byte sampled in cycle 1, in cycle 2. It requests no push and no jump.
- R11: A mode write with im_sel_i = 3 leaves the mode unchanged.
- R12: busy_o stays high for 11 cycles for a non-maskable entry, 13 for mode 0, 13 for mode 1 and 19 for mode 2, counted from the cycle after the deciding boundary. A boundary and any instruction flags raised while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boundary_i | input | 1 | An instruction completes in this cycle |
| di_i | input | 1 | Completing instruction is disable-interrupts |
| ei_i | input | 1 | Completing instruction is enable-interrupts |
| retn_i | input | 1 | Completing instruction is return-from-non-maskable |
| im_wr_i | input | 1 | Completing instruction selects a mode |
| im_sel_i | input | 2 | Mode selected with im_wr_i (0, 1, 2; 3 ignored) |
| irq_ni | input | 1 | Maskable request, level, active low |
| nmi_ni | input | 1 | Non-maskable request, falling edge, active low |
| page_i | input | 8 | Interrupt page register |
| bus_i | input | 8 | Data bus byte driven by the device |
| iff1_o | output | 1 | Live enable flip-flop |
| iff2_o | output | 1 | Saved enable flip-flop |
| mode_o | output | 2 | Current maskable mode |
| busy_o | output | 1 | Entry sequence running |
| ack_o | output | 1 | Maskable acknowledge cycle |
| push_pc_o | output | 1 | Request to push PC |
| tbl_rd_o | output | 1 | Request to read the mode 2 table word |
| tbl_addr_o | output | 16 | Mode 2 table address |
| op_vld_o | output | 1 | Mode 0 opcode hand-off strobe |
| op_o | output | 8 | Mode 0 opcode |
| jump_o | output | 1 | Jump to fixed handler |
| target_o | output | 16 | Fixed handler address, valid with jump_o |

## Verification
Each of the three maskable modes runs through a sweep of device bytes and page values. The sweep separates the table address formed in mode 2 from the raw byte handed off in mode 0, and shows whether bit 0 of the device byte is really dropped. The enable flip-flops are exercised with enable, disable and return-from-non-maskable in sequences that tell apart the one-instruction delay, the immediate block and the restore path. Non-maskable requests arrive as a single-cycle pulse, as a held level, alongside a maskable request, under disable, and in the middle of a running entry. These cases separate edge capture from level sensing, priority from masking, and a pending request from a lost one.

// File: rtl/intr_pkg.sv
package intr_pkg;
  typedef enum logic [1:0] {
    K_IM0 = 2'd0,
    K_IM1 = 2'd1,
    K_IM2 = 2'd2,
    K_NMI = 2'd3
  } kind_e;

  localparam logic [15:0] NMI_ADDR = 16'h0066;
  localparam logic [15:0] RST_ADDR = 16'h0038;
endpackage

// File: rtl/intr_nmi_edge.sv
module intr_nmi_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_ni,
  input  logic clr_i,
  output logic pend_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   pend_q;
  logic                   lvl;
  logic                   fall;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= nmi_ni;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], nmi_ni};
      end
    end
  endgenerate

  assign lvl  = sync_q[SYNC_STAGES-1];
  assign fall = prev_q & ~lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl;
      // a new edge wins over a clear in the same cycle
      pend_q <= fall | (pend_q & ~clr_i);
    end
  end

  assign pend_o = pend_q;

  p_pend_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !clr_i |=> pend_q);
  p_fall_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall |=> pend_q);
endmodule

// File: rtl/intr_enable.sv
module intr_enable
  import intr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       boundary_i,
  input  logic       busy_i,
  input  logic       di_i,
  input  logic       ei_i,
  input  logic       retn_i,
  input  logic       im_wr_i,
  input  logic [1:0] im_sel_i,
  input  logic       irq_ni,
  input  logic       nmi_pend_i,
  output logic       take_o,
  output kind_e      kind_o,
  output logic       nmi_clr_o,
  output logic       iff1_o,
  output logic       iff2_o,
  output logic [1:0] mode_o
);
  logic       iff1_q, iff2_q;
  logic       iff1_n, iff2_n;
  logic [1:0] mode_q, mode_n;
  logic       act;
  logic       take_nmi, take_irq;

  assign act = boundary_i & ~busy_i;

  // effect of the completing instruction, before the take decision
  always_comb begin
    iff1_n = iff1_q;
    iff2_n = iff2_q;
    if (act) begin
      if (di_i) begin
        iff1_n = 1'b0;
        iff2_n = 1'b0;
      end else if (ei_i) begin
        iff1_n = 1'b1;
        iff2_n = 1'b1;
      end else if (retn_i) begin
        iff1_n = iff2_q;
      end
    end
  end

  assign mode_n = (act && im_wr_i && (im_sel_i != 2'b11)) ? im_sel_i : mode_q;

  assign take_nmi = act & nmi_pend_i;
  assign take_irq = act & ~nmi_pend_i & ~irq_ni & iff1_n & ~ei_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iff1_q <= 1'b0;
      iff2_q <= 1'b0;
      mode_q <= 2'd0;
    end else begin
      mode_q <= mode_n;
      if (take_nmi) begin
        iff1_q <= 1'b0;
        iff2_q <= iff1_n;
      end else if (take_irq) begin
        iff1_q <= 1'b0;
        iff2_q <= 1'b0;
      end else begin
        iff1_q <= iff1_n;
        iff2_q <= iff2_n;
      end
    end
  end

  assign take_o    = take_nmi | take_irq;
  assign kind_o    = take_nmi ? K_NMI : kind_e'(mode_n);
  assign nmi_clr_o = take_nmi;
  assign iff1_o    = iff1_q;
  assign iff2_o    = iff2_q;
  assign mode_o    = mode_q;

  p_nmi_clr_iff1_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_nmi |=> !iff1_q && (iff2_q == $past(iff1_n)));
  p_retn_restore_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act && retn_i && !di_i && !ei_i && !take_o |=> iff1_q == $past(iff2_q));
  p_irq_clr_both_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_irq |=> !iff1_q && !iff2_q);
  p_mode_legal_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q != 2'b11);
endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
  import intr_pkg::*;
#(
  parameter int NMI_CYC = 11,
  parameter int IM0_CYC = 13,
  parameter int IM1_CYC = 13,
  parameter int IM2_CYC = 19
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  kind_e       kind_i,
  input  logic [7:0]  page_i,
  input  logic [7:0]  bus_i,
  output logic        busy_o,
  output logic        ack_o,
  output logic        push_pc_o,
  output logic        tbl_rd_o,
  output logic [15:0] tbl_addr_o,
  output logic        op_vld_o,
  output logic [7:0]  op_o,
  output logic        jump_o,
  output logic [15:0] target_o
);
  localparam int MAX_A = (NMI_CYC > IM0_CYC) ? NMI_CYC : IM0_CYC;
  localparam int MAX_B = (IM1_CYC > IM2_CYC) ? IM1_CYC : IM2_CYC;
  localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAXC + 1);
  localparam logic [CW-1:0] C1    = CW'(1);
  localparam logic [CW-1:0] C2    = CW'(2);
  localparam logic [CW-1:0] L_NMI = CW'(NMI_CYC);
  localparam logic [CW-1:0] L_IM0 = CW'(IM0_CYC);
  localparam logic [CW-1:0] L_IM1 = CW'(IM1_CYC);
  localparam logic [CW-1:0] L_IM2 = CW'(IM2_CYC);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] len;
  kind_e         kind_q;
  logic [7:0]    vec_q, page_q;
  logic          maskable;

  always_comb begin
    case (kind_q)
      K_IM0:   len = L_IM0;
      K_IM1:   len = L_IM1;
      K_IM2:   len = L_IM2;
      default: len = L_NMI;
    endcase
  end

  assign maskable = (kind_q != K_NMI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      kind_q <= K_IM0;
      vec_q  <= '0;
      page_q <= '0;
    end else begin
      if (start_i) begin
        cnt_q  <= C1;
        kind_q <= kind_i;
      end else if (cnt_q != '0) begin
        cnt_q <= (cnt_q == len) ? '0 : cnt_q + 1'b1;
      end
      // device byte is valid during the acknowledge cycle
      if (cnt_q == C1 && maskable) begin
        vec_q  <= bus_i;
        page_q <= page_i;
      end
    end
  end

  assign busy_o     = (cnt_q != '0);
  assign ack_o      = (cnt_q == C1) && maskable;
  assign push_pc_o  = (cnt_q == C2) && (kind_q != K_IM0);
  assign tbl_rd_o   = (cnt_q == C2) && (kind_q == K_IM2);
  assign op_vld_o   = (cnt_q == C2) && (kind_q == K_IM0);
  assign jump_o     = busy_o && (cnt_q == len) && (kind_q == K_NMI || kind_q == K_IM1);
  assign tbl_addr_o = {page_q, vec_q[7:1], 1'b0};
  assign op_o       = vec_q;
  assign target_o   = (kind_q == K_NMI) ? NMI_ADDR : RST_ADDR;

  p_start_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
  p_end_kind_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(jump_o) || kind_q == K_IM0 || kind_q == K_IM2);
  p_tbl_with_push_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_rd_o |-> push_pc_o && !op_vld_o);
endmodule

// File: rtl/intr_accept_unit.sv
module intr_accept_unit
  import intr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NMI_CYC     = 11,
  parameter int IM0_CYC     = 13,
  parameter int IM1_CYC     = 13,
  parameter int IM2_CYC     = 19
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        boundary_i,
  input  logic        di_i,
  input  logic        ei_i,
  input  logic        retn_i,
  input  logic        im_wr_i,
  input  logic [1:0]  im_sel_i,
  input  logic        irq_ni,
  input  logic        nmi_ni,
  input  logic [7:0]  page_i,
  input  logic [7:0]  bus_i,
  output logic        iff1_o,
  output logic        iff2_o,
  output logic [1:0]  mode_o,
  output logic        busy_o,
  output logic        ack_o,
  output logic        push_pc_o,
  output logic        tbl_rd_o,
  output logic [15:0] tbl_addr_o,
  output logic        op_vld_o,
  output logic [7:0]  op_o,
  output logic        jump_o,
  output logic [15:0] target_o
);
  logic  nmi_pend, nmi_clr, take;
  kind_e kind;

  intr_nmi_edge #(.SYNC_STAGES(SYNC_STAGES)) nmi_edge_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nmi_ni (nmi_ni),
    .clr_i  (nmi_clr),
    .pend_o (nmi_pend)
  );

  intr_enable enable_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .boundary_i (boundary_i),
    .busy_i     (busy_o),
    .di_i       (di_i),
    .ei_i       (ei_i),
    .retn_i     (retn_i),
    .im_wr_i    (im_wr_i),
    .im_sel_i   (im_sel_i),
    .irq_ni     (irq_ni),
    .nmi_pend_i (nmi_pend),
    .take_o     (take),
    .kind_o     (kind),
    .nmi_clr_o  (nmi_clr),
    .iff1_o     (iff1_o),
    .iff2_o     (iff2_o),
    .mode_o     (mode_o)
  );

  intr_entry_seq #(
    .NMI_CYC (NMI_CYC),
    .IM0_CYC (IM0_CYC),
    .IM1_CYC (IM1_CYC),
    .IM2_CYC (IM2_CYC)
  ) entry_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (take),
    .kind_i     (kind),
    .page_i     (page_i),
    .bus_i      (bus_i),
    .busy_o     (busy_o),
    .ack_o      (ack_o),
    .push_pc_o  (push_pc_o),
    .tbl_rd_o   (tbl_rd_o),
    .tbl_addr_o (tbl_addr_o),
    .op_vld_o   (op_vld_o),
    .op_o       (op_o),
    .jump_o     (jump_o),
    .target_o   (target_o)
  );

  p_nmi_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && nmi_pend |=> !ack_o);
  p_irq_gated_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && !nmi_pend |-> !irq_ni && !busy_o);
endmodule

// File: tb/intr_accept_unit_tb.sv
module intr_accept_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        boundary_i = 1'b0, di_i = 1'b0, ei_i = 1'b0, retn_i = 1'b0, im_wr_i = 1'b0;
  logic [1:0]  im_sel_i = 2'd0;
  logic        irq_ni = 1'b1, nmi_ni = 1'b1;
  logic [7:0]  page_i = 8'h00, bus_i = 8'h00;
  logic        iff1_o, iff2_o, busy_o, ack_o, push_pc_o, tbl_rd_o, op_vld_o, jump_o;
  logic [1:0]  mode_o;
  logic [15:0] tbl_addr_o, target_o;
  logic [7:0]  op_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  intr_accept_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .boundary_i(boundary_i), .di_i(di_i), .ei_i(ei_i),
    .retn_i(retn_i), .im_wr_i(im_wr_i), .im_sel_i(im_sel_i), .irq_ni(irq_ni),
    .nmi_ni(nmi_ni), .page_i(page_i), .bus_i(bus_i), .iff1_o(iff1_o), .iff2_o(iff2_o),
    .mode_o(mode_o), .busy_o(busy_o), .ack_o(ack_o), .push_pc_o(push_pc_o),
    .tbl_rd_o(tbl_rd_o), .tbl_addr_o(tbl_addr_o), .op_vld_o(op_vld_o), .op_o(op_o),
    .jump_o(jump_o), .target_o(target_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic instr(input bit di, input bit ei, input bit retn, input bit imw,
                       input logic [1:0] ims);
    boundary_i = 1'b1; di_i = di; ei_i = ei; retn_i = retn; im_wr_i = imw; im_sel_i = ims;
    tick();
    boundary_i = 1'b0; di_i = 1'b0; ei_i = 1'b0; retn_i = 1'b0; im_wr_i = 1'b0;
  endtask

  task automatic nmi_pulse();
    nmi_ni = 1'b0;
    tick();
    nmi_ni = 1'b1;
  endtask

  function automatic int len_of(input int kind);
    case (kind)
      0: return 13;
      1: return 13;
      2: return 19;
      default: return 11;
    endcase
  endfunction

  // called in cycle 1 of an entry; kind 0..2 = maskable mode, 3 = non-maskable
  task automatic entry(input int kind, input logic [7:0] pg, input logic [7:0] vc,
                       input int inj, input string req);
    int k = 1;
    int len = len_of(kind);
    logic [4:0] exp_v, act_v;
    while (busy_o && k < 64) begin
      exp_v = {(k == 1) && (kind != 3), (k == 2) && (kind != 0), (k == 2) && (kind == 2),
               (k == 2) && (kind == 0), (k == len) && (kind == 1 || kind == 3)};
      act_v = {ack_o, push_pc_o, tbl_rd_o, op_vld_o, jump_o};
      chk(act_v == exp_v, req, int'(act_v), int'(exp_v));
      if (k == 2 && kind == 2)
        chk(tbl_addr_o == {pg, vc[7:1], 1'b0}, "R9 table address", int'(tbl_addr_o),
            int'({pg, vc[7:1], 1'b0}));
      if (k == 2 && kind == 0)
        chk(op_o == vc, "R10 opcode", int'(op_o), int'(vc));
      if (jump_o)
        chk(target_o == ((kind == 3) ? 16'h0066 : 16'h0038), (kind == 3) ? "R6 target" : "R8 target",
            int'(target_o), (kind == 3) ? 32'h66 : 32'h38);
      if (inj == 1 && k == 3) begin boundary_i = 1'b1; ei_i = 1'b1; irq_ni = 1'b0; end
      if (inj == 2 && k == 3) nmi_ni = 1'b0;
      if (inj != 0 && k == 4) begin boundary_i = 1'b0; ei_i = 1'b0; nmi_ni = 1'b1; end
      tick();
      k++;
    end
    chk((k - 1) == len, "R12 entry length", k - 1, len);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();

    // R1 reset state
    chk({iff1_o, iff2_o, mode_o, busy_o, ack_o, push_pc_o, tbl_rd_o, op_vld_o, jump_o} == 10'd0,
        "R1 reset", int'({iff1_o, iff2_o, mode_o, busy_o, ack_o, push_pc_o, tbl_rd_o, op_vld_o, jump_o}), 0);
    instr(0, 0, 0, 0, 2'd0);
    chk(busy_o == 1'b0, "R1 no pending nmi after reset", busy_o, 0);

    // R2 request while disabled is not taken
    irq_ni = 1'b0;
    instr(0, 0, 0, 0, 2'd0);
    chk(busy_o == 1'b0, "R2 disabled", busy_o, 0);

    // R3 enable boundary blocks, next boundary takes (mode 0)
    bus_i = 8'hC7;
    instr(0, 1, 0, 0, 2'd0);
    chk(busy_o == 1'b0, "R3 blocked at enable", busy_o, 0);
    chk(iff1_o && iff2_o, "R3 enables set", int'({iff1_o, iff2_o}), 3);
    instr(0, 0, 0, 0, 2'd0);
    chk(busy_o == 1'b1, "R3 taken after next instruction", busy_o, 1);
    entry(0, 8'h00, 8'hC7, 0, "R10 mode 0 strobes");
    chk(!iff1_o && !iff2_o, "R7 cleared", int'({iff1_o, iff2_o}), 0);
    irq_ni = 1'b1;

    // R8 R9 R10 sweep over modes, bytes and pages
    for (int m = 0; m < 3; m++) begin
      for (int v = 0; v < 256; v += 23) begin
        irq_ni = 1'b1;
        instr(0, 0, 0, 1, 2'(m));
        chk(mode_o == 2'(m), "R11 mode write", mode_o, m);
        instr(0, 1, 0, 0, 2'd0);
        page_i = 8'(v) ^ 8'hA5;
        bus_i  = 8'(v) | 8'h01;
        irq_ni = 1'b0;
        instr(0, 0, 0, 0, 2'd0);
        entry(m, 8'(v) ^ 8'hA5, 8'(v) | 8'h01, 0,
              (m == 0) ? "R10 sweep" : (m == 1) ? "R8 sweep" : "R9 sweep");
        chk(!iff1_o && !iff2_o, "R7 sweep cleared", int'({iff1_o, iff2_o}), 0);
      end
    end
    irq_ni = 1'b1;

    // R11 code 3 ignored
    instr(0, 0, 0, 1, 2'd1);
    instr(0, 0, 0, 1, 2'd3);
    chk(mode_o == 2'd1, "R11 code 3 ignored", mode_o, 1);

    // R2 disable boundary takes nothing
    instr(0, 1, 0, 0, 2'd0);
    irq_ni = 1'b0;
    instr(1, 0, 0, 0, 2'd0);
    chk(busy_o == 1'b0, "R2 disable blocks", busy_o, 0);
    chk(!iff1_o && !iff2_o, "R2 disable clears", int'({iff1_o, iff2_o}), 0);
    irq_ni = 1'b1;

    // R6 nmi with enables set, then restore
    instr(0, 1, 0, 0, 2'd0);
    nmi_pulse();
    repeat (5) tick();
    instr(0, 0, 0, 0, 2'd0);
    entry(3, 8'h00, 8'h00, 0, "R6 nmi strobes");
    chk(!iff1_o && iff2_o, "R6 nmi saves enable", int'({iff1_o, iff2_o}), 1);
    instr(0, 0, 1, 0, 2'd0);
    chk(busy_o == 1'b0, "R6 retn no entry", busy_o, 0);
    chk(iff1_o && iff2_o, "R6 retn restores", int'({iff1_o, iff2_o}), 3);

    // R4 held low level serviced once
    instr(1, 0, 0, 0, 2'd0);
    nmi_ni = 1'b0;
    repeat (5) tick();
    instr(0, 0, 0, 0, 2'd0);
    entry(3, 8'h00, 8'h00, 0, "R4 held nmi taken");
    instr(0, 0, 0, 0, 2'd0);
    chk(busy_o == 1'b0, "R4 level does not retrigger", busy_o, 0);
    chk(!iff1_o && !iff2_o, "R5 nmi under disable", int'({iff1_o, iff2_o}), 0);
    nmi_ni = 1'b1;
    repeat (4) tick();

    // R5 priority over simultaneous maskable request
    instr(0, 1, 0, 0, 2'd0);
    irq_ni = 1'b0;
    nmi_pulse();
    repeat (5) tick();
    instr(0, 0, 0, 0, 2'd0);
    entry(3, 8'h00, 8'h00, 0, "R5 nmi wins");
    instr(0, 0, 0, 0, 2'd0);
    chk(busy_o == 1'b0, "R6 live enable cleared by nmi", busy_o, 0);
    instr(0, 0, 1, 0, 2'd0);
    chk(busy_o == 1'b1, "R2 taken at retn boundary", busy_o, 1);
    entry(1, 8'h00, 8'h00, 0, "R8 after retn");
    irq_ni = 1'b1;

    // R12 boundary during busy ignored
    instr(0, 1, 0, 0, 2'd0);
    irq_ni = 1'b0;
    instr(0, 0, 0, 0, 2'd0);
    entry(1, 8'h00, 8'h00, 1, "R12 busy ignores boundary");
    chk(!iff1_o && !iff2_o, "R12 enable flag ignored", int'({iff1_o, iff2_o}), 0);
    irq_ni = 1'b1;

    // R4 pulse arriving mid-entry is kept
    instr(0, 1, 0, 0, 2'd0);
    irq_ni = 1'b0;
    instr(0, 0, 0, 0, 2'd0);
    irq_ni = 1'b1;
    entry(1, 8'h00, 8'h00, 2, "R4 entry with pulse");
    instr(0, 0, 0, 0, 2'd0);
    chk(busy_o == 1'b1, "R4 pulse not lost", busy_o, 1);
    entry(3, 8'h00, 8'h00, 0, "R4 late nmi");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule